// File: doc/BRIEF.md
# Measurement Cycle Multiplexer Sequencer

This block decides which input the measurement multiplexer presents to the converter next. It steps through four kinds of slot: pressure conversions, auto-zero conversions taken with the inputs shorted, temperature conversions, and a common-mode check that is used to detect sensor aging. For each slot it presents a channel code and pulses a start request to the converter. It then holds the code until the converter reports completion, and tags that result with the channel that produced it.

After reset a start routine runs once. It fills in pressure, the pressure offset and the first temperature with its offset, and the second temperature with its offset when that source is enabled. The block then enters a repeating loop. In the loop, every auxiliary slot is followed by a burst of pressure conversions whose length is a configured power of two. A single configuration bit removes the second-temperature slots and their bursts from the loop. A watchdog counts wait cycles and raises a sticky flag when the converter stays silent for too long.

Top module: `msq_sequencer`

## Requirements
- R1: In the first cycle after reset is released, `adc_start` is 1, `chan` is 0, `res_valid` is 0 and `timeout_err` is 0.
- R2: `adc_start` is high for exactly one cycle per slot. In the following cycles the block waits with `chan` held until `adc_done` is seen high. An `adc_done` that arrives in the cycle `adc_start` is high is ignored.
- R3: The channel codes are 0 pressure, 1 pressure auto-zero, 2 first-temperature auto-zero, 3 first temperature, 4 second-temperature auto-zero, 5 second temperature and 6 common mode. Code 7 never appears.
- R4: After reset the start routine issues codes 0, 1, 2, 3 in that order. It then issues 4, 5 when `cfg_t2_en` is 1. This happens once, and the loop follows.
- R5: The loop issues the auxiliary codes 2, 3, 1, 4, 5, 6 in that order and repeats them. Each auxiliary code is followed by exactly 2^`cfg_pmc_sel` pressure slots (code 0), so the burst length is 1 to 128.
- R6: With `cfg_t2_en` = 0, codes 4 and 5 and the pressure bursts that follow them are absent from the loop. Code 1's burst is followed directly by code 6.
- R7: In the cycle after an accepted `adc_done`, `res_valid` is 1 for one cycle and `res_tag` equals the code of the slot that finished. The next slot's `adc_start` rises in that same cycle.
- R8: If `cfg_wd_limit` is nonzero and `cfg_wd_limit` consecutive wait cycles pass without `adc_done`, `timeout_err` goes to 1 in the next cycle and stays there until reset. The block keeps waiting. A limit of 0 disables the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pmc_sel | input | PMC_SEL_W | Burst length exponent (burst = 2^value) |
| cfg_t2_en | input | 1 | Enables the second-temperature slots |
| cfg_wd_limit | input | WD_W | Wait-cycle limit for the watchdog, 0 disables it |
| adc_done | input | 1 | Converter completion strobe |
| adc_start | output | 1 | One-cycle conversion request |
| chan | output | 3 | Channel code of the current slot |
| res_valid | output | 1 | Result strobe |
| res_tag | output | 3 | Channel code of the finished result |
| timeout_err | output | 1 | Sticky watchdog flag |

## Verification
The result strobe for one slot and the start pulse of the next slot always fall in the same cycle. So `res_tag` must show the old channel while `chan` already shows the new one. Completion strobes are returned after zero to four wait cycles, and spurious strobes are also driven during start cycles. This places that shared cycle directly after every kind of slot transition: into a burst, out of a burst, and from the start routine into the loop. A reference model that steps through a list of expected codes is compared with both fields in every cycle. The watchdog limit is also driven to exactly the stall length and to one cycle more than the stall length, which checks the boundary of the timeout.

// File: rtl/msq_pkg.sv
package msq_pkg;

   typedef enum logic [2:0] {
      CH_PRES    = 3'd0,
      CH_PRES_AZ = 3'd1,
      CH_TA_AZ   = 3'd2,
      CH_TA      = 3'd3,
      CH_TB_AZ   = 3'd4,
      CH_TB      = 3'd5,
      CH_CMODE   = 3'd6
   } chan_e;

   localparam int CHAN_W     = 3;
   localparam int BOOT_LEN   = 6;
   localparam int AUX_LEN    = 6;
   localparam int BOOT_T1END = 3;

   // Slot list of the one-time start routine
   function automatic chan_e boot_chan(input logic [2:0] idx);
      case (idx)
         3'd0:    return CH_PRES;
         3'd1:    return CH_PRES_AZ;
         3'd2:    return CH_TA_AZ;
         3'd3:    return CH_TA;
         3'd4:    return CH_TB_AZ;
         default: return CH_TB;
      endcase
   endfunction

   // Auxiliary slot order of the steady loop
   function automatic chan_e aux_chan(input logic [2:0] idx);
      case (idx)
         3'd0:    return CH_TA_AZ;
         3'd1:    return CH_TA;
         3'd2:    return CH_PRES_AZ;
         3'd3:    return CH_TB_AZ;
         3'd4:    return CH_TB;
         default: return CH_CMODE;
      endcase
   endfunction

   // Next auxiliary index; the second-temperature pair is skipped when disabled
   function automatic logic [2:0] aux_next(input logic [2:0] idx, input logic tb_en);
      if (idx == 3'(AUX_LEN - 1))  return 3'd0;
      if (idx == 3'd2 && !tb_en)   return 3'(AUX_LEN - 1);
      return idx + 3'd1;
   endfunction

endpackage

// File: rtl/msq_slot_gen.sv
module msq_slot_gen
   import msq_pkg::*;
#(
   parameter int PMC_SEL_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PMC_SEL_W-1:0] pmc_sel,
   input  logic                 tb_en,
   input  logic                 advance,
   output logic [CHAN_W-1:0]    chan,
   output logic                 in_boot
);

   localparam int BURST_W = (1 << PMC_SEL_W) - 1;

   initial begin
      assert (PMC_SEL_W >= 1 && PMC_SEL_W <= 4)
         else $error("msq_slot_gen: PMC_SEL_W out of range");
   end

   logic [2:0]         boot_idx;
   logic [2:0]         aux_idx;
   logic               in_burst;
   logic [BURST_W-1:0] burst_cnt;
   logic [BURST_W:0]   burst_len;
   logic [BURST_W-1:0] burst_last;
   logic               boot_done;

   assign burst_len  = (BURST_W+1)'(1) << pmc_sel;
   assign burst_last = BURST_W'(burst_len - 1'b1);
   assign boot_done  = (boot_idx == 3'(BOOT_LEN - 1)) ||
                       (boot_idx == 3'(BOOT_T1END) && !tb_en);

   always_comb begin
      if (in_boot)       chan = boot_chan(boot_idx);
      else if (in_burst) chan = CH_PRES;
      else               chan = aux_chan(aux_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_boot   <= 1'b1;
         boot_idx  <= 3'd0;
         aux_idx   <= 3'd0;
         in_burst  <= 1'b0;
         burst_cnt <= '0;
      end else if (advance) begin
         if (in_boot) begin
            if (boot_done) begin
               in_boot  <= 1'b0;
               in_burst <= 1'b0;
               aux_idx  <= 3'd0;
            end else begin
               boot_idx <= boot_idx + 3'd1;
            end
         end else if (!in_burst) begin
            in_burst  <= 1'b1;
            burst_cnt <= '0;
         end else if (burst_cnt >= burst_last) begin
            in_burst <= 1'b0;
            aux_idx  <= aux_next(aux_idx, tb_en);
         end else begin
            burst_cnt <= burst_cnt + 1'b1;
         end
      end
   end

   // R4: the start routine is left once and never re-entered
   a_r4_boot_once: assert property (@(posedge clk) disable iff (!rst_n)
      !in_boot |=> !in_boot);

   // R3: the illegal code never reaches the multiplexer
   a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      chan != 3'd7);

endmodule

// File: rtl/msq_handshake.sv
module msq_handshake
   import msq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adc_done,
   input  logic [CHAN_W-1:0] chan,
   output logic              adc_start,
   output logic              waiting,
   output logic              accept,
   output logic              res_valid,
   output logic [CHAN_W-1:0] res_tag
);

   assign adc_start = !waiting;
   assign accept    = waiting && adc_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waiting   <= 1'b0;
         res_valid <= 1'b0;
         res_tag   <= '0;
      end else begin
         res_valid <= accept;
         if (accept) res_tag <= chan;
         if (!waiting)      waiting <= 1'b1;
         else if (adc_done) waiting <= 1'b0;
      end
   end

   // R2: a start request never lasts two cycles
   a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);

   // R7: every accepted completion yields a result strobe next cycle
   a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && adc_done) |=> res_valid);

endmodule

// File: rtl/msq_watchdog.sv
module msq_watchdog #(
   parameter int WD_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            waiting,
   input  logic            adc_done,
   input  logic [WD_W-1:0] limit,
   output logic            err
);

   initial begin
      assert (WD_W >= 2 && WD_W <= 32)
         else $error("msq_watchdog: WD_W out of range");
   end

   logic [WD_W-1:0] wcnt;
   logic            idle_tick;

   assign idle_tick = waiting && !adc_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt <= '0;
         err  <= 1'b0;
      end else begin
         if (!waiting)                         wcnt <= '0;
         else if (idle_tick && wcnt != '1)     wcnt <= wcnt + 1'b1;
         if (idle_tick && limit != '0 && wcnt == WD_W'(limit - 1'b1))
            err <= 1'b1;
      end
   end

   // R8: the flag is sticky
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R8: a zero limit never raises the flag
   a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0 && !err) |=> !err);

endmodule

// File: rtl/msq_sequencer.sv
module msq_sequencer
   import msq_pkg::*;
#(
   parameter int PMC_SEL_W = 3,
   parameter int WD_W      = 12,
   parameter bit WDOG_EN   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PMC_SEL_W-1:0] cfg_pmc_sel,
   input  logic                 cfg_t2_en,
   input  logic [WD_W-1:0]      cfg_wd_limit,
   input  logic                 adc_done,
   output logic                 adc_start,
   output logic [2:0]           chan,
   output logic                 res_valid,
   output logic [2:0]           res_tag,
   output logic                 timeout_err
);

   logic waiting;
   logic accept;
   logic in_boot;

   msq_slot_gen #(.PMC_SEL_W(PMC_SEL_W)) u_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .pmc_sel (cfg_pmc_sel),
      .tb_en   (cfg_t2_en),
      .advance (accept),
      .chan    (chan),
      .in_boot (in_boot)
   );

   msq_handshake u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .adc_done  (adc_done),
      .chan      (chan),
      .adc_start (adc_start),
      .waiting   (waiting),
      .accept    (accept),
      .res_valid (res_valid),
      .res_tag   (res_tag)
   );

   generate
      if (WDOG_EN) begin : g_wdog
         msq_watchdog #(.WD_W(WD_W)) u_wd (
            .clk      (clk),
            .rst_n    (rst_n),
            .waiting  (waiting),
            .adc_done (adc_done),
            .limit    (cfg_wd_limit),
            .err      (timeout_err)
         );
      end else begin : g_nowdog
         assign timeout_err = 1'b0;
      end
   endgenerate

   // R2: the channel is held while a conversion is outstanding
   a_r2_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_start && !adc_done) |=> $stable(chan));

   // R7: the result strobe coincides with the next start request
   a_r7_strobe_with_start: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> adc_start);

   // R4: while the routine runs with the second source off, its codes stay out
   a_r4_boot_no_tb: assert property (@(posedge clk) disable iff (!rst_n)
      (in_boot && !cfg_t2_en) |-> (chan != 3'd4 && chan != 3'd5));

endmodule

// File: tb/test_msq_sequencer.sv
`timescale 1ns/1ps
module test_msq_sequencer;

   localparam int SW = 3;
   localparam int TW = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [SW-1:0] sel;
   logic          t2;
   logic [TW-1:0] lim;
   logic          done;
   logic          adc_start, res_valid, timeout_err;
   logic [2:0]    chan, res_tag;

   always #2.5 clk = ~clk;

   msq_sequencer #(.PMC_SEL_W(SW), .WD_W(TW)) i_msq_sequencer (
      .clk(clk), .rst_n(rst_n), .cfg_pmc_sel(sel), .cfg_t2_en(t2),
      .cfg_wd_limit(lim), .adc_done(done), .adc_start(adc_start),
      .chan(chan), .res_valid(res_valid), .res_tag(res_tag),
      .timeout_err(timeout_err)
   );

   int checks = 0;
   int fails  = 0;
   int q[$];
   int qi, slen, m_tag, m_cnt, wdly, stall_at, stall_len, seed, cyc;
   bit m_wait, m_rv, m_err;

   function automatic int aux_code(int a);
      case (a)
         0: return 2;
         1: return 3;
         2: return 1;
         3: return 4;
         4: return 5;
         default: return 6;
      endcase
   endfunction

   // expected slot list built from R4, R5 and R6
   function automatic void build(int s, bit tb);
      q.delete();
      q.push_back(0); q.push_back(1); q.push_back(2); q.push_back(3);
      if (tb) begin q.push_back(4); q.push_back(5); end
      slen = q.size();
      while (q.size() < 2000) begin
         for (int a = 0; a < 6; a++) begin
            if (!tb && (a == 3 || a == 4)) continue;
            q.push_back(aux_code(a));
            for (int k = 0; k < (1 << s); k++) q.push_back(0);
         end
      end
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic step();
      int  tgt;
      bit  d;
      bit  was_wait;
      string creq;
      creq = (qi < slen) ? "R3 R4" : (t2 ? "R3 R5" : "R3 R6");
      chk(adc_start == !m_wait, "R2", "adc_start", adc_start, !m_wait);
      chk(chan == q[qi], creq, "chan", chan, q[qi]);
      chk(res_valid == m_rv, "R7", "res_valid", res_valid, m_rv);
      if (m_rv) chk(res_tag == m_tag, "R7", "res_tag", res_tag, m_tag);
      chk(timeout_err == m_err, "R8", "timeout_err", timeout_err, m_err);
      // responder: completion after a delay; stray strobes during start (R2)
      if (m_wait) begin
         tgt = (qi == stall_at) ? stall_len : ((qi * 7 + seed) % 5);
         d = (wdly == tgt);
         wdly++;
      end else begin
         d = ((cyc + seed) % 3 == 0);
      end
      done = d;
      was_wait = m_wait;
      m_rv = was_wait && d;
      if (m_rv) m_tag = q[qi];
      if (!was_wait) begin
         m_wait = 1'b1; m_cnt = 0; wdly = 0;
      end else if (d) begin
         m_wait = 1'b0; qi++;
      end else begin
         m_cnt++;
         if (lim != 0 && m_cnt == int'(lim)) m_err = 1'b1;
      end
      cyc++;
   endtask

   task automatic run(int s, bit tb, int l, int sa, int sl, int sd, int n);
      @(negedge clk);
      rst_n = 1'b0; done = 1'b0;
      sel = SW'(s); t2 = tb; lim = TW'(l);
      stall_at = sa; stall_len = sl; seed = sd;
      build(s, tb);
      qi = 0; m_wait = 0; m_rv = 0; m_err = 0; m_tag = 0; m_cnt = 0; wdly = 0; cyc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state seen before the first active edge
      chk(adc_start == 1'b1, "R1", "adc_start", adc_start, 1);
      chk(chan == 3'd0, "R1", "chan", chan, 0);
      chk(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
      chk(timeout_err == 1'b0, "R1", "timeout_err", timeout_err, 0);
      for (int i = 0; i < n; i++) begin
         step();
         @(negedge clk);
      end
   endtask

   initial begin
      #(200000 * 5);
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; done = 1'b0; sel = '0; t2 = 1'b0; lim = '0;
      run(0, 1'b1, 0,  -1, 0,  1, 1500);  // R5 burst of one, second source on
      run(2, 1'b0, 30, -1, 0,  2, 2000);  // R6 skip, burst of four
      run(7, 1'b1, 50, -1, 0,  3, 3000);  // R5 longest burst
      run(1, 1'b1, 20,  5, 35, 4, 1000);  // R8 stall beyond limit
      run(1, 1'b0, 0,   8, 60, 5, 1000);  // R8 limit zero disables
      run(3, 1'b0, 5,  -1, 0,  6, 1500);  // R8 delays just under the limit
      run(3, 1'b1, 5,  10, 5,  7, 1500);  // R8 stall exactly at the limit
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule